// File: doc/BRIEF.md
# Binary BCH Error-Locator Polynomial Solver

This block turns the 2t syndromes of a binary BCH codeword into the error-locator polynomial sigma(x) and its degree L. It runs the binary-BCH form of the Berlekamp iteration: the row index mu advances by two per step, a single best earlier row serves as the correction source, and the run stops early once enough zero discrepancies have been seen. Arithmetic in GF(2^M) is done through log and antilog tables. The surrounding logic supplies these tables as combinational lookups, together with the syndrome register file, which it exposes as a combinational read port.

A pulse on `start` begins a solve. The block reads the syndromes it needs and, one field product per cycle, builds each new polynomial and the next discrepancy. It then raises `done`. `sigma` and `deg_out` hold the result, and `done` stays high until the next `start`. The parameters are the field width M and the correction capability T; the defaults are M=13 and T=8.

Top module: `bm_locator`

## Requirements
- R1: While reset is active and after it is released, `done` is 0, `deg_out` is 0 and `sigma` holds the constant polynomial 1. Coefficient k sits in `sigma[k*M +: M]`.
- R2: In the cycle after `start` is sampled, `done` is 0. Once `done` rises, it stays high until the next `start`.
- R3: If every syndrome is zero, the result is sigma(x)=1 with degree 0.
- R4: For a single error at position p, the result has degree 1, coefficient 0 equal to 1 and coefficient 1 equal to alpha^p.
- R5: For e <= T distinct error positions, the degree equals e. The coefficients equal those of the iteration with initial rows (mu=-1, sigma=1, d=1, L=0, delta=-1) and (mu=0, sigma=1, d=S1, L=0, delta=0), where row i+1 has mu=2i and delta=mu-L.
- R6: On a nonzero discrepancy d_i, the correction row ro is the earlier row with a nonzero discrepancy and the largest delta. On a tie the earliest such row wins. If no such row beats delta -1, row 0 is used.
- R7: A zero discrepancy copies sigma and L forward and increments a counter that is never cleared during a solve. When L < T, the solve ends as soon as that counter reaches floor(a/2)+2 for odd a or floor(a/2)+1 for even a, where a = T-L-1. With all-zero syndromes, `done` therefore rises 2*limit clock edges after the edge that samples `start`; this is 10 for T=8.
- R8: On a nonzero discrepancy, the new sigma is sigma_i XOR (d_i/d_ro)*x^(mu_i-mu_ro)*sigma_ro. The new degree is max(L_i, L_ro+mu_i-mu_ro). Division is log a + (N - log b) mod N, with N = 2^M-1.
- R9: The next discrepancy is S(2i+1) XOR the sum over k=1..L of sigma_k*S(2i+1-k). Terms with a zero operand are skipped, and no discrepancy is formed after iteration T. Every syndrome read uses an index from 1 to 2T.
- R10: The degree saturates at T, and terms that would land above x^T are dropped. `deg_out` never exceeds T, even with more than T errors.
- R11: When `done` is high, coefficient 0 is 1 and every coefficient above `deg_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a solve (one-cycle pulse) |
| syn_idx | output | $clog2(2T+1) | Syndrome register file read index (1..2T) |
| syn_val | input | M | Syndrome at `syn_idx`, same cycle |
| lga_addr | output | M | Log table lookup A, field element |
| lga_data | input | M | Log of `lga_addr` |
| lgb_addr | output | M | Log table lookup B, field element |
| lgb_data | input | M | Log of `lgb_addr` |
| alog_addr | output | M | Antilog table lookup, exponent 0..N-1 |
| alog_data | input | M | alpha^`alog_addr` |
| done | output | 1 | Result valid, held until next start |
| deg_out | output | $clog2(T+1) | Degree L of sigma(x) |
| sigma | output | (T+1)*M | Coefficients of sigma(x), coefficient k at bits k*M |

## Verification
In the closing cycle of a polynomial update, two things happen on the same edge. The row just processed may replace the stored correction row, and the current row is replaced by the newly built polynomial. The stored row must capture the old polynomial, its delta and its discrepancy, not the new ones. Error patterns with two or more errors provoke this handover at nearly every step, and random syndrome vectors that contain zeros add runs of zero discrepancy between handovers. The bench judges the result by comparing every coefficient and the degree against a bench model that keeps the full row history and searches it afresh at each step.

// File: rtl/bm_pkg.sv
package bm_pkg;

    // Solver sequence: load S1, decide per iteration, apply the
    // correction term by term, then accumulate the next discrepancy.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LOAD = 3'd1,
        ST_STEP = 3'd2,
        ST_CORR = 3'd3,
        ST_DISC = 3'd4,
        ST_DONE = 3'd5
    } bm_state_e;

endpackage

// File: rtl/bm_log_add.sv
// Adds two discrete logs modulo N = 2^M - 1. Operand b may equal N,
// so a divisor's negated log can be fed in directly.
module bm_log_add #(
    parameter int M = 13
) (
    input  logic [M-1:0] a_i,
    input  logic [M:0]   b_i,
    output logic [M-1:0] sum_o
);
    localparam int N = (1 << M) - 1;

    logic [M:0] raw;

    assign raw   = {1'b0, a_i} + b_i;
    assign sum_o = (raw >= (M+1)'(N)) ? M'(raw - (M+1)'(N)) : M'(raw);

endmodule

// File: rtl/bm_stop_limit.sv
// Number of zero discrepancies that ends a solve early, for the
// current degree. It is only meaningful when the degree is below T.
module bm_stop_limit #(
    parameter int T = 8
) (
    input  logic [$clog2(T+1)-1:0] deg_i,
    output logic [$clog2(T+1):0]   limit_o
);
    localparam int DW = $clog2(T + 1);

    int slack;

    always_comb begin
        slack = T - int'(deg_i) - 1;
        if (slack < 0)
            limit_o = '1;
        else
            limit_o = (DW+1)'(slack / 2 + (((slack % 2) != 0) ? 2 : 1));
    end

endmodule

// File: rtl/bm_locator.sv
module bm_locator
    import bm_pkg::*;
#(
    parameter int M = 13,
    parameter int T = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    output logic [$clog2(2*T+1)-1:0]     syn_idx,
    input  logic [M-1:0]                 syn_val,
    output logic [M-1:0]                 lga_addr,
    input  logic [M-1:0]                 lga_data,
    output logic [M-1:0]                 lgb_addr,
    input  logic [M-1:0]                 lgb_data,
    output logic [M-1:0]                 alog_addr,
    input  logic [M-1:0]                 alog_data,
    output logic                         done,
    output logic [$clog2(T+1)-1:0]       deg_out,
    output logic [(T+1)*M-1:0]           sigma
);
    localparam int N  = (1 << M) - 1;
    localparam int DW = $clog2(T + 1);
    localparam int IW = $clog2(2 * T + 1);
    localparam int SW = $clog2(2 * T + 2) + 2;

    typedef logic signed [SW-1:0] sw_t;
    typedef logic [T:0][M-1:0]    poly_t;

    // One row of the iteration: polynomial, degree, mu, delta, discrepancy.
    typedef struct packed {
        poly_t        sig;
        logic [DW-1:0] deg;
        sw_t          mu;
        sw_t          dlt;
        logic [M-1:0] dis;
    } row_t;

    typedef struct packed {
        bm_state_e     st;
        row_t          cur;   // row i being processed
        row_t          best;  // correction row ro for row i
        poly_t         nsig;  // polynomial under construction
        logic [DW-1:0] ndeg;
        logic [M-1:0]  lr;    // log(d_i / d_ro)
        logic [DW-1:0] it;    // iteration i, 1..T
        logic [DW-1:0] k;     // term index
        logic [DW:0]   zc;    // zero-discrepancy count
        sw_t           diff;  // mu_i - mu_ro
    } regs_t;

    regs_t r_q, r_d;

    logic [M-1:0] corr_coef, disc_coef;
    logic [M:0]   ratio_b;
    logic [M-1:0] ratio_log;
    logic [M-1:0] prod_a;
    logic [M:0]   prod_b;
    logic [M-1:0] prod_log;
    logic [DW:0]  zlimit;
    logic [DW:0]  zc_inc;
    poly_t        nsig_w;
    int           diff_i, cand_i, nd_i, tgt_i;
    sw_t          mu_next;

    assign corr_coef = r_q.best.sig[r_q.k];
    assign disc_coef = r_q.cur.sig[r_q.k];
    assign ratio_b   = (M+1)'(N) - {1'b0, lgb_data};
    assign zc_inc    = r_q.zc + (DW+1)'(1);
    assign mu_next   = sw_t'(2 * int'(r_q.it));

    bm_log_add #(.M(M)) u_ratio (
        .a_i   (lga_data),
        .b_i   (ratio_b),
        .sum_o (ratio_log)
    );

    bm_log_add #(.M(M)) u_prod (
        .a_i   (prod_a),
        .b_i   (prod_b),
        .sum_o (prod_log)
    );

    bm_stop_limit #(.T(T)) u_lim (
        .deg_i   (r_q.cur.deg),
        .limit_o (zlimit)
    );

    // Syndrome read index
    always_comb begin
        syn_idx = '0;
        if (r_q.st == ST_LOAD)
            syn_idx = IW'(1);
        else if (r_q.st == ST_DISC)
            syn_idx = IW'(2 * int'(r_q.it) + 1 - int'(r_q.k));
    end

    // Log table addresses
    always_comb begin
        lga_addr = '0;
        lgb_addr = '0;
        case (r_q.st)
            ST_STEP: begin
                lga_addr = r_q.cur.dis;
                lgb_addr = r_q.best.dis;
            end
            ST_CORR: lga_addr = corr_coef;
            ST_DISC: begin
                lga_addr = disc_coef;
                lgb_addr = syn_val;
            end
            default: ;
        endcase
    end

    // Product operands for the shared exponent adder
    always_comb begin
        prod_a = '0;
        prod_b = '0;
        if (r_q.st == ST_CORR) begin
            prod_a = r_q.lr;
            prod_b = {1'b0, lga_data};
        end else if (r_q.st == ST_DISC) begin
            prod_a = lga_data;
            prod_b = {1'b0, lgb_data};
        end
    end

    assign alog_addr = prod_log;

    // Next-state logic
    always_comb begin
        r_d    = r_q;
        nsig_w = r_q.nsig;
        diff_i = int'($signed(r_q.cur.mu)) - int'($signed(r_q.best.mu));
        cand_i = int'(r_q.best.deg) + diff_i;
        nd_i   = (int'(r_q.cur.deg) > cand_i) ? int'(r_q.cur.deg) : cand_i;
        if (nd_i > T) nd_i = T;
        tgt_i  = int'(r_q.k) + int'($signed(r_q.diff));

        case (r_q.st)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    r_d.cur.sig     = '0;
                    r_d.cur.sig[0]  = M'(1);
                    r_d.cur.deg     = '0;
                    r_d.cur.mu      = '0;
                    r_d.cur.dlt     = '0;
                    r_d.cur.dis     = '0;
                    r_d.best.sig    = '0;
                    r_d.best.sig[0] = M'(1);
                    r_d.best.deg    = '0;
                    r_d.best.mu     = sw_t'(-1);
                    r_d.best.dlt    = sw_t'(-1);
                    r_d.best.dis    = M'(1);
                    r_d.it          = DW'(1);
                    r_d.k           = '0;
                    r_d.zc          = '0;
                    r_d.st          = ST_LOAD;
                end
            end

            ST_LOAD: begin
                r_d.cur.dis = syn_val;
                r_d.st      = ST_STEP;
            end

            ST_STEP: begin
                if (r_q.cur.dis == '0) begin
                    r_d.zc = zc_inc;
                    if ((int'(r_q.cur.deg) < T) && (zc_inc == zlimit)) begin
                        r_d.st = ST_DONE;
                    end else begin
                        r_d.cur.mu  = mu_next;
                        r_d.cur.dlt = sw_t'(2 * int'(r_q.it) - int'(r_q.cur.deg));
                        if (int'(r_q.it) == T) begin
                            r_d.st = ST_DONE;
                        end else begin
                            r_d.k  = '0;
                            r_d.st = ST_DISC;
                        end
                    end
                end else begin
                    r_d.lr   = ratio_log;
                    r_d.diff = sw_t'(diff_i);
                    r_d.ndeg = DW'(nd_i);
                    r_d.nsig = r_q.cur.sig;
                    r_d.k    = '0;
                    r_d.st   = ST_CORR;
                end
            end

            ST_CORR: begin
                if (corr_coef != '0) begin
                    for (int j = 0; j <= T; j++) begin
                        if (j == tgt_i)
                            nsig_w[j] = nsig_w[j] ^ alog_data;
                    end
                end
                r_d.nsig = nsig_w;
                if (r_q.k == r_q.best.deg) begin
                    if ($signed(r_q.cur.dlt) > $signed(r_q.best.dlt))
                        r_d.best = r_q.cur;
                    r_d.cur.sig = nsig_w;
                    r_d.cur.deg = r_q.ndeg;
                    r_d.cur.mu  = mu_next;
                    r_d.cur.dlt = sw_t'(2 * int'(r_q.it) - int'(r_q.ndeg));
                    r_d.k       = '0;
                    r_d.st      = (int'(r_q.it) == T) ? ST_DONE : ST_DISC;
                end else begin
                    r_d.k = r_q.k + DW'(1);
                end
            end

            ST_DISC: begin
                if (r_q.k == '0)
                    r_d.cur.dis = syn_val;
                else if ((disc_coef != '0) && (syn_val != '0))
                    r_d.cur.dis = r_q.cur.dis ^ alog_data;
                if (r_q.k == r_q.cur.deg) begin
                    r_d.it = r_q.it + DW'(1);
                    r_d.st = ST_STEP;
                end else begin
                    r_d.k = r_q.k + DW'(1);
                end
            end

            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q            <= '0;
            r_q.cur.sig[0] <= M'(1);
        end else begin
            r_q <= r_d;
        end
    end

    assign done    = (r_q.st == ST_DONE);
    assign deg_out = r_q.cur.deg;
    assign sigma   = r_q.cur.sig;

    // ---------------- assertions ----------------
    assert_deg_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(deg_out) <= T);

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done);

    assert_done_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    assert_const_one_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sigma[M-1:0] == M'(1)));

    assert_syn_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_LOAD) || (r_q.st == ST_DISC)) |->
            ((int'(syn_idx) >= 1) && (int'(syn_idx) <= 2 * T)));

    assert_ro_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CORR) |-> ((r_q.best.dis != '0) && (r_q.cur.dis != '0)));

    assert_exp_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CORR) |-> (int'(alog_addr) < N));

    for (genvar j = 1; j <= T; j++) begin : g_upper
        assert_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (done && (int'(deg_out) < j)) |-> (sigma[j*M +: M] == '0));
    end

endmodule

// File: tb/bm_locator_test.sv
module bm_locator_test;
    localparam int CLK_PERIOD = 10;
    localparam int M    = 8;
    localparam int T    = 8;
    localparam int N    = (1 << M) - 1;
    localparam int PRIM = 'h11D;
    localparam int IW   = $clog2(2 * T + 1);
    localparam int DW   = $clog2(T + 1);

    logic clk, rst_n, start;
    logic [IW-1:0]      syn_idx;
    logic [M-1:0]       syn_val;
    logic [M-1:0]       lga_addr, lga_data, lgb_addr, lgb_data, alog_addr, alog_data;
    logic               done;
    logic [DW-1:0]      deg_out;
    logic [(T+1)*M-1:0] sigma;

    logic [M-1:0] alog_tab [0:(1<<M)-1];
    logic [M-1:0] log_tab  [0:(1<<M)-1];
    logic [M-1:0] syn_mem  [0:(1<<IW)-1];

    int checks = 0;
    int fails  = 0;
    int exp_sig [0:T];
    int exp_deg;
    int err_pos [0:T+3];

    assign lga_data  = log_tab[lga_addr];
    assign lgb_data  = log_tab[lgb_addr];
    assign alog_data = alog_tab[alog_addr];
    assign syn_val   = syn_mem[syn_idx];

    bm_locator #(.M(M), .T(T)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .syn_idx(syn_idx), .syn_val(syn_val),
        .lga_addr(lga_addr), .lga_data(lga_data),
        .lgb_addr(lgb_addr), .lgb_data(lgb_data),
        .alog_addr(alog_addr), .alog_data(alog_data),
        .done(done), .deg_out(deg_out), .sigma(sigma)
    );

    initial begin
        clk = 0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int gf_mul(input int a, input int b);
        if (a == 0 || b == 0) return 0;
        return int'(alog_tab[(int'(log_tab[a]) + int'(log_tab[b])) % N]);
    endfunction

    function automatic int gf_div(input int a, input int b);
        if (a == 0) return 0;
        return int'(alog_tab[(int'(log_tab[a]) + N - int'(log_tab[b])) % N]);
    endfunction

    function automatic int coef(input int k);
        return int'(sigma[k*M +: M]);
    endfunction

    // Bench model with the full row history, searched afresh each step.
    task automatic ref_solve();
        int sg [0:T+1][0:T];
        int dg [0:T+1];
        int mu [0:T+1];
        int dl [0:T+1];
        int dd [0:T+1];
        int zc, fin, ro, big, df, nd, a, lim, q;
        for (int r = 0; r <= T + 1; r++) begin
            for (int k = 0; k <= T; k++) sg[r][k] = 0;
            dg[r] = 0; mu[r] = 0; dl[r] = 0; dd[r] = 0;
        end
        sg[0][0] = 1; mu[0] = -1; dl[0] = -1; dd[0] = 1;
        sg[1][0] = 1; mu[1] = 0;  dl[1] = 0;  dd[1] = int'(syn_mem[1]);
        zc = 0; fin = T + 1;
        for (int i = 1; i <= T; i++) begin
            if (dd[i] == 0) begin
                zc++;
                if (dg[i] < T) begin
                    a = T - dg[i] - 1;
                    lim = a / 2 + (((a % 2) != 0) ? 2 : 1);
                    if (zc == lim) begin
                        fin = i;
                        break;
                    end
                end
                for (int k = 0; k <= T; k++) sg[i+1][k] = sg[i][k];
                dg[i+1] = dg[i];
            end else begin
                ro = 0; big = -1;
                for (int j = 0; j < i; j++)
                    if (dd[j] != 0 && dl[j] > big) begin big = dl[j]; ro = j; end
                df = mu[i] - mu[ro];
                nd = dg[ro] + df;
                if (dg[i] > nd) nd = dg[i];
                if (nd > T) nd = T;
                dg[i+1] = nd;
                q = gf_div(dd[i], dd[ro]);
                for (int k = 0; k <= T; k++) sg[i+1][k] = sg[i][k];
                for (int k = 0; k <= dg[ro]; k++)
                    if (k + df <= T) sg[i+1][k+df] ^= gf_mul(q, sg[ro][k]);
            end
            mu[i+1] = 2 * i;
            dl[i+1] = 2 * i - dg[i+1];
            if (i < T) begin
                dd[i+1] = int'(syn_mem[2*i+1]);
                for (int k = 1; k <= dg[i+1]; k++)
                    dd[i+1] ^= gf_mul(sg[i+1][k], int'(syn_mem[2*i+1-k]));
            end
        end
        exp_deg = dg[fin];
        for (int k = 0; k <= T; k++) exp_sig[k] = sg[fin][k];
    endtask

    task automatic load_errors(input int cnt);
        int p;
        bit dup;
        for (int e = 0; e < cnt; e++) begin
            do begin
                p = int'($urandom % N);
                dup = 0;
                for (int f = 0; f < e; f++) if (err_pos[f] == p) dup = 1;
            end while (dup);
            err_pos[e] = p;
        end
        for (int j = 1; j <= 2 * T; j++) begin
            syn_mem[j] = '0;
            for (int e = 0; e < cnt; e++)
                syn_mem[j] = syn_mem[j] ^ alog_tab[(j * err_pos[e]) % N];
        end
    endtask

    task automatic run_solver(output int lat);
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        chk("R2 done low after start", int'(done), 0);
        lat = 0;
        while (!done && lat < 3000) begin
            @(negedge clk);
            lat++;
        end
        chk("R2 done reached", int'(done), 1);
    endtask

    task automatic cmp_ref(input string tag);
        ref_solve();
        chk({tag, " degree"}, int'(deg_out), exp_deg);
        for (int k = 0; k <= T; k++) chk({tag, " coefficient"}, coef(k), exp_sig[k]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int lat, x, cnt;
        void'($urandom(32'd4242));
        x = 1;
        for (int i = 0; i < N; i++) begin
            alog_tab[i] = M'(x);
            log_tab[x]  = M'(i);
            x = x << 1;
            if ((x & (1 << M)) != 0) x = x ^ PRIM;
        end
        log_tab[0] = '0;
        alog_tab[N] = M'(1);
        for (int j = 0; j < (1 << IW); j++) syn_mem[j] = '0;

        rst_n = 0; start = 0;
        repeat (3) @(negedge clk);
        chk("R1 done in reset", int'(done), 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 done after reset", int'(done), 0);
        chk("R1 degree after reset", int'(deg_out), 0);
        chk("R1 sigma0 after reset", coef(0), 1);
        chk("R1 sigma1 after reset", coef(1), 0);

        // All-zero syndromes: early stop path and its latency (R3, R7)
        run_solver(lat);
        chk("R7 zero-syndrome latency", lat, 10);
        chk("R3 degree", int'(deg_out), 0);
        chk("R3 sigma0", coef(0), 1);
        for (int k = 1; k <= T; k++) chk("R3 upper coefficient", coef(k), 0);
        repeat (3) @(negedge clk);
        chk("R2 done held", int'(done), 1);

        // Single errors (R4)
        err_pos[0] = 0;
        load_errors(0);
        for (int j = 1; j <= 2 * T; j++) syn_mem[j] = M'(1);
        run_solver(lat);
        chk("R4 degree pos0", int'(deg_out), 1);
        chk("R4 sigma1 pos0", coef(1), 1);
        chk("R4 sigma0 pos0", coef(0), 1);
        for (int j = 1; j <= 2 * T; j++) syn_mem[j] = alog_tab[(j * 37) % N];
        run_solver(lat);
        chk("R4 degree pos37", int'(deg_out), 1);
        chk("R4 sigma1 pos37", coef(1), int'(alog_tab[37]));
        for (int k = 2; k <= T; k++) chk("R11 upper zero", coef(k), 0);

        // Exactly T errors (R5)
        load_errors(T);
        run_solver(lat);
        chk("R5 degree at T errors", int'(deg_out), T);
        cmp_ref("R5/R6/R8");

        // Random error patterns, including beyond T (R5, R6, R8, R9, R10)
        for (int c = 0; c < 40; c++) begin
            cnt = int'($urandom % (T + 4));
            load_errors(cnt);
            run_solver(lat);
            if (cnt <= T) chk("R5 degree equals error count", int'(deg_out), cnt);
            chk("R10 degree bound", int'(int'(deg_out) <= T), 1);
            cmp_ref("R6/R8/R9 random errors");
        end

        // Arbitrary syndrome vectors with many zeros (R9, R10, R7)
        for (int c = 0; c < 20; c++) begin
            for (int j = 1; j <= 2 * T; j++)
                syn_mem[j] = (($urandom % 10) < 4) ? '0 : M'(($urandom % N) + 1);
            run_solver(lat);
            chk("R10 degree bound", int'(int'(deg_out) <= T), 1);
            chk("R11 sigma0", coef(0), 1);
            cmp_ref("R7/R9/R10 random syndromes");
        end

        // Start while done is held restarts cleanly (R2)
        load_errors(2);
        run_solver(lat);
        chk("R5 degree two errors", int'(deg_out), 2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule